// File: doc/BRIEF.md
# Four-phase ToF depth calculator

This block turns the correlation samples of one time-of-flight pixel into a phase angle and a confidence value. A two-tap pixel is measured at four illumination phase offsets (0°, 180°, 90° and 270°), which gives eight signed samples per pixel. Each sample arrives on a valid/ready stream and carries a tap bit and a phase code. When all eight have been accepted, the block forms the in-phase and quadrature differences of each tap and their L1 norms. It normalizes each difference by its own tap's norm with one shared sequential divider. It then combines the two taps in counter-phase and maps the result to degrees with a piecewise-linear rule instead of an arctangent.

The result is one pixel's phase in fixed-point degrees, wrapped into [0, 360), and a confidence equal to the summed norms. A flag marks pixels where either tap had no signal. The block works on one pixel at a time. It holds its input stalled from the eighth accepted sample until the result is presented. Conversion to distance, calibration and filtering happen downstream.

Top module: `tof_depth_core`

## Requirements
- R1: After reset, in_ready is 1, and out_valid, out_phase, out_conf and out_bad are all 0.
- R2: Each accepted sample is written to a slot chosen by in_tap (0 or 1) and in_phase (code 0 = 0°, 1 = 180°, 2 = 90°, 3 = 270°). A pixel is computed after every eighth accepted sample, and the result is the same whatever order the eight slots were filled in.
- R3: For tap k, X_k = S(k,0°) − S(k,180°), Y_k = S(k,270°) − S(k,90°) and N_k = |X_k| + |Y_k|. out_conf equals N0 + N1.
- R4: With F = FRAC_W, each quotient is the exact ratio truncated toward zero: qX_k = trunc(X_k·2^(F−1)/N_k) and qY_k = trunc(Y_k·2^(F−1)/N_k). The two taps are then combined in counter-phase: x = qX0 − qX1 and y = qY0 − qY1, in units of 2^−F.
- R5: The full-precision phase P, in units of 2^−F degrees, is 90·(2^F − x) when y < 0 and 90·(3·2^F + x) otherwise. out_phase is P shifted right by F − DEG_FRAC (truncated), in units of 2^−DEG_FRAC degrees.
- R6: A full-precision phase of exactly 360° is reported as 0, so out_phase always lies below 360·2^DEG_FRAC.
- R7: When a tap's norm is zero, that tap's quotients count as zero and out_bad is 1. Otherwise out_bad is 0.
- R8: When both norms are zero, out_phase is 0, out_conf is 0 and out_bad is 1.
- R9: in_ready is 0 from the cycle after the eighth accepted sample until the cycle in which out_valid is 1. A sample offered while in_ready is 0 is not taken and has no effect on any result.
- R10: out_valid is high for exactly one cycle per pixel. out_phase, out_conf and out_bad change only in that cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_tap | input | 1 | Tap index of the sample |
| in_phase | input | 2 | Phase code: 0=0°, 1=180°, 2=90°, 3=270° |
| in_sample | input | SAMPLE_W | Signed correlation sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_phase | output | DEG_FRAC+9 | Phase in units of 2^−DEG_FRAC degrees |
| out_conf | output | SAMPLE_W+2 | Confidence N0 + N1 |
| out_bad | output | 1 | A tap norm was zero |

## Verification
The bench builds the block with SAMPLE_W = 4, FRAC_W = 12 and DEG_FRAC = 4. The 4-bit samples give a divider of only fifteen steps, so a pixel finishes in under a hundred cycles. With this configuration the bench can sweep every tap-0 quadrature pair on a ±4 grid against several fixed tap-1 vectors. That sweep reaches every octant of the piecewise map, the y = 0 sign boundary, the exact 360° wrap and the zero-norm taps. A pseudo-random set of full-range pixels, a shuffled arrival order and samples offered while the block is busy complete the coverage.

// File: rtl/tof_pkg.sv
package tof_pkg;

    localparam int NUM_TAPS   = 2;
    localparam int NUM_PHASES = 4;
    localparam int NUM_SLOTS  = NUM_TAPS * NUM_PHASES;

    // Phase code carried with each sample; it selects the storage slot.
    localparam logic [1:0] PH_0   = 2'd0;
    localparam logic [1:0] PH_180 = 2'd1;
    localparam logic [1:0] PH_90  = 2'd2;
    localparam logic [1:0] PH_270 = 2'd3;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIV     = 2'd1,
        ST_EMIT    = 2'd2
    } tof_state_e;

endpackage

// File: rtl/tof_sample_store.sv
module tof_sample_store
    import tof_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_tap,
    input  logic [1:0]                      wr_phase,
    input  logic [SAMPLE_W-1:0]             wr_data,
    output logic [NUM_SLOTS*SAMPLE_W-1:0]   slots_o,
    output logic                            last_o
);

    localparam int CNT_W = $clog2(NUM_SLOTS);

    typedef struct packed {
        logic [CNT_W-1:0]                   cnt;
        logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] slot;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.slot[{wr_tap, wr_phase}] = wr_data;
            st_d.cnt                      = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots_o = st_q.slot;
    assign last_o  = wr_en && (st_q.cnt == CNT_W'(NUM_SLOTS - 1));

endmodule

// File: rtl/tof_quad_calc.sv
module tof_quad_calc
    import tof_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic [NUM_SLOTS*SAMPLE_W-1:0]        slots_i,
    output logic [NUM_TAPS-1:0][SAMPLE_W:0]      x_o,
    output logic [NUM_TAPS-1:0][SAMPLE_W:0]      y_o,
    output logic [NUM_TAPS-1:0][SAMPLE_W-1:0]    mag_x_o,
    output logic [NUM_TAPS-1:0][SAMPLE_W-1:0]    mag_y_o,
    output logic [NUM_TAPS-1:0][SAMPLE_W:0]      norm_o,
    output logic [SAMPLE_W+1:0]                  conf_o
);

    localparam int DW = SAMPLE_W + 1;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        logic signed [SAMPLE_W-1:0] s_a, s_b, s_c, s_d;
        logic signed [DW-1:0]       dx, dy, ax, ay;

        assign s_a = slots_i[(k*NUM_PHASES + int'(PH_0))   * SAMPLE_W +: SAMPLE_W];
        assign s_b = slots_i[(k*NUM_PHASES + int'(PH_180)) * SAMPLE_W +: SAMPLE_W];
        assign s_c = slots_i[(k*NUM_PHASES + int'(PH_90))  * SAMPLE_W +: SAMPLE_W];
        assign s_d = slots_i[(k*NUM_PHASES + int'(PH_270)) * SAMPLE_W +: SAMPLE_W];

        assign dx = DW'(s_a) - DW'(s_b);
        assign dy = DW'(s_d) - DW'(s_c);
        assign ax = dx[DW-1] ? -dx : dx;
        assign ay = dy[DW-1] ? -dy : dy;

        assign x_o[k]     = dx;
        assign y_o[k]     = dy;
        assign mag_x_o[k] = ax[SAMPLE_W-1:0];
        assign mag_y_o[k] = ay[SAMPLE_W-1:0];
        assign norm_o[k]  = ax + ay;
    end

    assign conf_o = {1'b0, norm_o[0]} + {1'b0, norm_o[1]};

endmodule

// File: rtl/tof_serial_div.sv
module tof_serial_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 13,
    parameter int SHIFT = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NUM_W-1:0]             num,
    input  logic [DEN_W-1:0]             den,
    output logic                         done,
    output logic [NUM_W+SHIFT-1:0]       quo
);

    localparam int DIV_W = NUM_W + SHIFT;
    localparam int CNT_W = $clog2(DIV_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [DIV_W-1:0] acc;
    } div_t;

    div_t dv_d, dv_q;

    logic [DEN_W:0] rem_sh;
    logic [DEN_W:0] rem_diff;
    logic           fits;

    always_comb begin
        rem_sh   = {dv_q.rem, dv_q.acc[DIV_W-1]};
        rem_diff = rem_sh - {1'b0, dv_q.den};
        fits     = (rem_sh >= {1'b0, dv_q.den});

        dv_d      = dv_q;
        dv_d.done = 1'b0;
        if (start) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CNT_W'(DIV_W);
            dv_d.den  = den;
            dv_d.rem  = '0;
            dv_d.acc  = DIV_W'(num) << SHIFT;
        end else if (dv_q.busy) begin
            dv_d.rem = fits ? rem_diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            dv_d.acc = {dv_q.acc[DIV_W-2:0], fits};
            dv_d.cnt = dv_q.cnt - CNT_W'(1);
            if (dv_q.cnt == CNT_W'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign done = dv_q.done;
    assign quo  = dv_q.acc;

endmodule

// File: rtl/tof_phase_map.sv
module tof_phase_map #(
    parameter int FRAC_W   = 14,
    parameter int DEG_FRAC = 4
) (
    input  logic signed [FRAC_W:0]    qx0,
    input  logic signed [FRAC_W:0]    qx1,
    input  logic signed [FRAC_W:0]    qy0,
    input  logic signed [FRAC_W:0]    qy1,
    input  logic                      both_zero,
    output logic [DEG_FRAC+8:0]       phase_o
);

    localparam int PW   = FRAC_W + 11;
    localparam int SH   = FRAC_W - DEG_FRAC;
    localparam int PH_W = DEG_FRAC + 9;

    localparam logic signed [PW-1:0] ONE_C   = PW'(1 << FRAC_W);
    localparam logic signed [PW-1:0] THREE_C = PW'(3 << FRAC_W);
    localparam logic signed [PW-1:0] FULL_C  = PW'(360 << FRAC_W);
    localparam logic signed [PW-1:0] K90     = PW'(90);

    logic signed [FRAC_W+1:0] x_s, y_s;
    logic signed [PW-1:0]     x_w, pf, pf_w;

    always_comb begin
        x_s = (FRAC_W+2)'(qx0) - (FRAC_W+2)'(qx1);
        y_s = (FRAC_W+2)'(qy0) - (FRAC_W+2)'(qy1);
        x_w = PW'(x_s);
        if (y_s < 0) begin
            pf = K90 * (ONE_C - x_w);
        end else begin
            pf = K90 * (THREE_C + x_w);
        end
        pf_w    = (pf >= FULL_C) ? (pf - FULL_C) : pf;
        phase_o = both_zero ? '0 : pf_w[SH +: PH_W];
    end

endmodule

// File: rtl/tof_depth_core.sv
module tof_depth_core
    import tof_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 14,
    parameter int DEG_FRAC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_tap,
    input  logic [1:0]              in_phase,
    input  logic [SAMPLE_W-1:0]     in_sample,
    output logic                    out_valid,
    output logic [DEG_FRAC+8:0]     out_phase,
    output logic [SAMPLE_W+1:0]     out_conf,
    output logic                    out_bad
);

    localparam int NORM_W = SAMPLE_W + 1;
    localparam int CONF_W = SAMPLE_W + 2;
    localparam int PH_W   = DEG_FRAC + 9;
    localparam int Q_W    = FRAC_W + 1;
    localparam int SHIFT  = FRAC_W - 1;
    localparam int DIV_W  = SAMPLE_W + SHIFT;

    typedef struct packed {
        tof_state_e               st;
        logic [1:0]               op;
        logic                     waiting;
        logic [3:0][Q_W-1:0]      quo;
        logic                     out_valid;
        logic [PH_W-1:0]          phase;
        logic [CONF_W-1:0]        conf;
        logic                     bad;
    } core_t;

    core_t core_d, core_q;

    logic [NUM_SLOTS*SAMPLE_W-1:0]         slots;
    logic                                  store_last;
    logic [NUM_TAPS-1:0][SAMPLE_W:0]       quad_x, quad_y;
    logic [NUM_TAPS-1:0][SAMPLE_W-1:0]     mag_x, mag_y;
    logic [NUM_TAPS-1:0][NORM_W-1:0]       norm;
    logic [CONF_W-1:0]                     conf_sum;
    logic                                  div_start, div_done;
    logic [DIV_W-1:0]                      div_quo;
    logic [SAMPLE_W-1:0]                   sel_num;
    logic [NORM_W-1:0]                     sel_den;
    logic                                  sel_neg;
    logic signed [Q_W-1:0]                 q_abs, q_signed;
    logic                                  zero0, zero1;
    logic [PH_W-1:0]                       map_phase;
    logic                                  advance;

    assign in_ready = (core_q.st == ST_COLLECT);

    tof_sample_store #(.SAMPLE_W(SAMPLE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid && in_ready),
        .wr_tap   (in_tap),
        .wr_phase (in_phase),
        .wr_data  (in_sample),
        .slots_o  (slots),
        .last_o   (store_last)
    );

    tof_quad_calc #(.SAMPLE_W(SAMPLE_W)) u_quad (
        .slots_i (slots),
        .x_o     (quad_x),
        .y_o     (quad_y),
        .mag_x_o (mag_x),
        .mag_y_o (mag_y),
        .norm_o  (norm),
        .conf_o  (conf_sum)
    );

    // Operation order: 0 = X0/N0, 1 = Y0/N0, 2 = X1/N1, 3 = Y1/N1.
    always_comb begin
        sel_den = norm[core_q.op[1]];
        if (core_q.op[0]) begin
            sel_num = mag_y[core_q.op[1]];
            sel_neg = quad_y[core_q.op[1]][SAMPLE_W];
        end else begin
            sel_num = mag_x[core_q.op[1]];
            sel_neg = quad_x[core_q.op[1]][SAMPLE_W];
        end
    end

    tof_serial_div #(
        .NUM_W (SAMPLE_W),
        .DEN_W (NORM_W),
        .SHIFT (SHIFT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (sel_num),
        .den   (sel_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign q_abs    = {1'b0, div_quo[FRAC_W-1:0]};
    assign q_signed = sel_neg ? -q_abs : q_abs;
    assign zero0    = (norm[0] == '0);
    assign zero1    = (norm[1] == '0);

    tof_phase_map #(.FRAC_W(FRAC_W), .DEG_FRAC(DEG_FRAC)) u_map (
        .qx0       ($signed(core_q.quo[0])),
        .qy0       ($signed(core_q.quo[1])),
        .qx1       ($signed(core_q.quo[2])),
        .qy1       ($signed(core_q.quo[3])),
        .both_zero (zero0 && zero1),
        .phase_o   (map_phase)
    );

    always_comb begin
        core_d           = core_q;
        core_d.out_valid = 1'b0;
        div_start        = 1'b0;
        advance          = 1'b0;
        unique case (core_q.st)
            ST_COLLECT: begin
                if (store_last) begin
                    core_d.st      = ST_DIV;
                    core_d.op      = 2'd0;
                    core_d.waiting = 1'b0;
                end
            end
            ST_DIV: begin
                if (!core_q.waiting) begin
                    if (sel_den == '0) begin
                        core_d.quo[core_q.op] = '0;
                        advance               = 1'b1;
                    end else begin
                        div_start      = 1'b1;
                        core_d.waiting = 1'b1;
                    end
                end else if (div_done) begin
                    core_d.quo[core_q.op] = q_signed;
                    core_d.waiting        = 1'b0;
                    advance               = 1'b1;
                end
            end
            ST_EMIT: begin
                core_d.out_valid = 1'b1;
                core_d.phase     = map_phase;
                core_d.conf      = conf_sum;
                core_d.bad       = zero0 || zero1;
                core_d.st        = ST_COLLECT;
            end
            default: core_d.st = ST_COLLECT;
        endcase
        if (advance) begin
            if (core_q.op == 2'd3) begin
                core_d.st = ST_EMIT;
            end else begin
                core_d.op = core_q.op + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= ST_COLLECT;
        end else begin
            core_q <= core_d;
        end
    end

    assign out_valid = core_q.out_valid;
    assign out_phase = core_q.phase;
    assign out_conf  = core_q.conf;
    assign out_bad   = core_q.bad;

endmodule

// File: rtl/tof_depth_core_chk.sv
module tof_depth_core_chk #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 14,
    parameter int DEG_FRAC = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    in_tap,
    input logic [1:0]              in_phase,
    input logic [SAMPLE_W-1:0]     in_sample,
    input logic                    out_valid,
    input logic [DEG_FRAC+8:0]     out_phase,
    input logic [SAMPLE_W+1:0]     out_conf,
    input logic                    out_bad
);

    localparam logic [DEG_FRAC+8:0] TURN = (DEG_FRAC+9)'(360 << DEG_FRAC);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_phase) || !$stable(out_conf) || !$stable(out_bad)) |-> out_valid);

    // R9
    emit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_phase < TURN));

    // R8
    empty_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_conf == '0) |-> (out_phase == '0 && out_bad));

endmodule

bind tof_depth_core tof_depth_core_chk #(
    .SAMPLE_W (SAMPLE_W),
    .FRAC_W   (FRAC_W),
    .DEG_FRAC (DEG_FRAC)
) u_chk (.*);

// File: tb/tof_depth_core_bench.sv
module tof_depth_core_bench;

    localparam int SW   = 4;
    localparam int FW   = 12;
    localparam int DF   = 4;
    localparam int ONE  = 1 << FW;
    localparam int HALF = 1 << (FW - 1);
    localparam int SH   = FW - DF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic            in_tap = 1'b0;
    logic [1:0]      in_phase = 2'd0;
    logic [SW-1:0]   in_sample = '0;
    logic            out_valid;
    logic [DF+8:0]   out_phase;
    logic [SW+1:0]   out_conf;
    logic            out_bad;

    int checks = 0;
    int failures = 0;
    int smp [2][4];
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    tof_depth_core #(.SAMPLE_W(SW), .FRAC_W(FW), .DEG_FRAC(DF)) u_tof_depth_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_tap    (in_tap),
        .in_phase  (in_phase),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_phase (out_phase),
        .out_conf  (out_conf),
        .out_bad   (out_bad)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int quot(input int n, input int d);
        if (d == 0) return 0;
        return (n * HALF) / d;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected result from the requirement arithmetic (R3, R4, R5, R6, R7, R8).
    task automatic expect_pixel(output int e_ph, output int e_conf, output int e_bad);
        int x0, y0, x1, y1, n0, n1, x, y, pf;
        x0 = smp[0][0] - smp[0][1];
        y0 = smp[0][3] - smp[0][2];
        x1 = smp[1][0] - smp[1][1];
        y1 = smp[1][3] - smp[1][2];
        n0 = iabs(x0) + iabs(y0);
        n1 = iabs(x1) + iabs(y1);
        x  = quot(x0, n0) - quot(x1, n1);
        y  = quot(y0, n0) - quot(y1, n1);
        pf = (y < 0) ? 90 * (ONE - x) : 90 * (3 * ONE + x);
        if (pf >= 360 * ONE) pf -= 360 * ONE;
        e_ph   = (n0 == 0 && n1 == 0) ? 0 : pf / (1 << SH);
        e_conf = n0 + n1;
        e_bad  = (n0 == 0 || n1 == 0) ? 1 : 0;
    endtask

    task automatic send_one(input int t, input int p, input int v);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_tap    = t[0];
        in_phase  = p[1:0];
        in_sample = v[SW-1:0];
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_pixel(input bit reversed);
        if (!reversed) begin
            for (int p = 0; p < 4; p++)
                for (int t = 0; t < 2; t++)
                    send_one(t, p, smp[t][p]);
        end else begin
            for (int i = 7; i >= 0; i--)
                send_one(i % 2, i / 2, smp[i % 2][i / 2]);
        end
    endtask

    task automatic wait_check(input string req_ph);
        int e_ph, e_conf, e_bad, n, held;
        expect_pixel(e_ph, e_conf, e_bad);
        n = 0;
        while (!out_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R10", "out_valid seen", int'(out_valid), 1);
        chk(req_ph, "phase", int'(out_phase), e_ph);
        chk("R3", "confidence", int'(out_conf), e_conf);
        chk("R7", "bad flag", int'(out_bad), e_bad);
        held = int'(out_phase);
        @(negedge clk);
        chk("R10", "strobe length", int'(out_valid), 0);
        chk("R10", "phase held", int'(out_phase), held);
    endtask

    task automatic set_quad(input int t, input int xv, input int yv, input int off);
        smp[t][1] = off;
        smp[t][0] = xv + off;
        smp[t][2] = off;
        smp[t][3] = yv + off;
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[19:16]) - 8;
    endfunction

    initial begin
        int t1x [4] = '{0, 3, -5, 2};
        int t1y [4] = '{0, -2, 1, 6};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_phase", int'(out_phase), 0);
        chk("R1", "out_conf", int'(out_conf), 0);
        chk("R1", "out_bad", int'(out_bad), 0);

        // R8 both norms zero
        set_quad(0, 0, 0, 3);
        set_quad(1, 0, 0, -2);
        send_pixel(1'b0);
        wait_check("R8");

        // R7 one tap empty
        set_quad(0, 3, -1, 0);
        set_quad(1, 0, 0, 1);
        send_pixel(1'b0);
        wait_check("R7");
        set_quad(0, 0, 0, 0);
        set_quad(1, -2, -4, 0);
        send_pixel(1'b0);
        wait_check("R7");

        // R6 exact 360 degree wrap
        set_quad(0, 5, 0, 0);
        set_quad(1, -3, 0, 0);
        send_pixel(1'b0);
        wait_check("R6");

        // R2 reversed arrival order
        set_quad(0, 4, -3, -1);
        set_quad(1, -2, 5, 1);
        send_pixel(1'b1);
        wait_check("R2");

        // R9 samples offered while busy are ignored
        set_quad(0, -3, -4, 2);
        set_quad(1, 1, 2, -1);
        send_pixel(1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9", "in_ready low while busy", int'(in_ready), 0);
            in_valid  = 1'b1;
            in_tap    = i[0];
            in_phase  = i[1:0];
            in_sample = 4'd7;
        end
        @(negedge clk);
        in_valid = 1'b0;
        wait_check("R9");
        set_quad(0, 2, 2, 0);
        set_quad(1, -1, 3, 0);
        send_pixel(1'b0);
        wait_check("R9");

        // R4 R5 sweep of tap-0 quadratures against fixed tap-1 vectors
        for (int a = -4; a <= 4; a++)
            for (int b = -4; b <= 4; b++)
                for (int j = 0; j < 4; j++) begin
                    set_quad(0, a, b, (a + b) % 2);
                    set_quad(1, t1x[j], t1y[j], 0);
                    send_pixel(1'b0);
                    wait_check("R4 R5");
                end

        // R3 R5 pseudo-random full-range samples
        for (int i = 0; i < 200; i++) begin
            for (int t = 0; t < 2; t++)
                for (int p = 0; p < 4; p++)
                    smp[t][p] = rnd();
            send_pixel(1'b0);
            wait_check("R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule